// File: doc/BRIEF.md
# Configuration change protection unit

This block guards the critical control registers of a small processor system and its privileged flash instructions. Software unlocks a short timed window by writing a signature byte to a key register. One signature opens a window in which a single write to a protected control register may take effect. The other opens a window in which a flash store or flash load instruction may run. The window counts retired instructions and closes after a fixed number of them. Certain instruction classes also close it early, and these classes differ between the two modes.

A write that comes from the DMA master never opens a window, and DMA traffic does not disturb a window that is already open. While a window is open the block asks the interrupt controller to hold every request pending, non-maskable ones included. A protected register write is granted only when all of the following hold: the register-write window is open, the target lies in the protected address range, the change-enable bit is set in the same data byte, and the lock fuse is intact. The active mode is available on a port so that software can read back the state of the window.

Top module: `cfg_guard`

## Requirements
- R1: While rst_ni is low, and on the first cycle after reset, io_open_o, nvm_open_o, prot_wr_o and irq_hold_o are 0 and mode_o is 0.
- R2: A CPU write of SIG_IO (default 8'hA5) to KEY_ADDR (default 16'h0034) sets io_open_o and mode_o=1 from the next cycle. A CPU write of SIG_NVM (default 8'h5A) sets nvm_open_o and mode_o=2. mode_o=0 means no window.
- R3: After it opens, a window stays open through WIN_LEN-1 (default 3) retire_i pulses and closes on the cycle after the WIN_LEN-th pulse. A retire_i pulse in the same cycle as the signature write is not counted.
- R4: A DMA write (dma_wr_i) to the key register opens no window, and DMA writes do not close an open window.
- R5: irq_hold_o is 1 exactly in the cycles where io_open_o or nvm_open_o is 1.
- R6: In register-write mode the window closes on the next cycle after any CPU write to an address other than the key register, or after a retire_i pulse that carries ins_store_i, ins_load_i or ins_sleep_i.
- R7: In flash-instruction mode the window closes on the next cycle after a CPU write at an address at or above IO_LIMIT (default 16'h1000), or after a retire_i pulse that carries ins_sleep_i. CPU writes below IO_LIMIT and retires with ins_store_i or ins_load_i leave it open.
- R8: prot_wr_o is 1 in the same cycle as a CPU write only when the register-write window is open, addr_i lies in [PROT_BASE, PROT_BASE+PROT_NUM) (default 16'h0040..16'h0047) and wdata_i[CE_BIT] (default bit 0) is 1. The window is closed on the next cycle.
- R9: While fuse_lock_i is 1, prot_wr_o stays 0 even when every other condition of R8 holds.
- R10: A CPU write of any non-signature value to the key register closes an open window and opens none.
- R11: A signature write while a window is open switches to the newly selected mode and restarts the count at WIN_LEN retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU write strobe |
| dma_wr_i | input | 1 | DMA write strobe |
| addr_i | input | AW | Write address |
| wdata_i | input | 8 | Write data |
| retire_i | input | 1 | One pulse per retired instruction |
| ins_store_i | input | 1 | Retired instruction is a flash store |
| ins_load_i | input | 1 | Retired instruction is a flash load |
| ins_sleep_i | input | 1 | Retired instruction is a sleep |
| fuse_lock_i | input | 1 | Lock fuse blown |
| io_open_o | output | 1 | Register-write window open |
| nvm_open_o | output | 1 | Flash-instruction window open |
| prot_wr_o | output | 1 | Protected write granted |
| irq_hold_o | output | 1 | Hold interrupts pending |
| mode_o | output | 2 | Mode readback: 0 none, 1 register write, 2 flash instruction |

## Verification
The window is opened in each mode and run with plain retire pulses. This separates the count-out path from every early close, and the fourth pulse separates an off-by-one count from a correct one. Each early-close class is then applied in both modes: I/O writes, data-memory writes, store, load and sleep retires. The pairs of patterns show whether the mode-specific cancel sets were swapped or merged. Protected writes are tried with each grant condition removed one at a time (address, change-enable bit, window, fuse). DMA key writes, wrong key values and a signature write mid-window cover the remaining paths into and out of the window.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_IO   = 2'd1,
    MODE_NVM  = 2'd2
  } guard_mode_e;
endpackage

// File: rtl/cfg_guard_decode.sv
module cfg_guard_decode #(
  parameter int unsigned     AW        = 16,
  parameter logic [AW-1:0]   KEY_ADDR  = 16'h0034,
  parameter logic [AW-1:0]   IO_LIMIT  = 16'h1000,
  parameter logic [AW-1:0]   PROT_BASE = 16'h0040,
  parameter int unsigned     PROT_NUM  = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic          key_hit_o,
  output logic          io_space_o,
  output logic          prot_hit_o
);
  localparam logic [AW-1:0] PROT_END = AW'(PROT_BASE + AW'(PROT_NUM));

  assign key_hit_o  = (addr_i == KEY_ADDR);
  assign io_space_o = (addr_i < IO_LIMIT);
  assign prot_hit_o = (addr_i >= PROT_BASE) && (addr_i < PROT_END);
endmodule

// File: rtl/cfg_guard_window.sv
module cfg_guard_window
  import cfg_guard_pkg::*;
#(
  parameter int unsigned WIN_LEN = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sig_io_i,
  input  logic        sig_nvm_i,
  input  logic        bad_key_i,
  input  logic        retire_i,
  input  logic        cancel_io_i,
  input  logic        cancel_nvm_i,
  output guard_mode_e mode_o
);
  localparam int unsigned CW = $clog2(WIN_LEN + 1);

  guard_mode_e   mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cancel;

  assign cancel = (mode_q == MODE_IO  && cancel_io_i) ||
                  (mode_q == MODE_NVM && cancel_nvm_i);

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (sig_io_i) begin
      mode_d = MODE_IO;
      cnt_d  = CW'(WIN_LEN);
    end else if (sig_nvm_i) begin
      mode_d = MODE_NVM;
      cnt_d  = CW'(WIN_LEN);
    end else if (bad_key_i || cancel) begin
      mode_d = MODE_NONE;
      cnt_d  = '0;
    end else if (mode_q != MODE_NONE && retire_i) begin
      if (cnt_q <= CW'(1)) begin
        mode_d = MODE_NONE;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NONE;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter logic [AW-1:0] KEY_ADDR  = 16'h0034,
  parameter logic [AW-1:0] IO_LIMIT  = 16'h1000,
  parameter logic [AW-1:0] PROT_BASE = 16'h0040,
  parameter int unsigned   PROT_NUM  = 8,
  parameter int unsigned   CE_BIT    = 0,
  parameter logic [7:0]    SIG_IO    = 8'hA5,
  parameter logic [7:0]    SIG_NVM   = 8'h5A,
  parameter int unsigned   WIN_LEN   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_wr_i,
  input  logic          dma_wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          retire_i,
  input  logic          ins_store_i,
  input  logic          ins_load_i,
  input  logic          ins_sleep_i,
  input  logic          fuse_lock_i,
  output logic          io_open_o,
  output logic          nvm_open_o,
  output logic          prot_wr_o,
  output logic          irq_hold_o,
  output logic [1:0]    mode_o
);
  logic        key_hit, io_space, prot_hit;
  logic        key_wr, sig_io, sig_nvm, bad_key;
  logic        other_wr, cancel_io, cancel_nvm;
  guard_mode_e mode;

  cfg_guard_decode #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .IO_LIMIT(IO_LIMIT),
    .PROT_BASE(PROT_BASE), .PROT_NUM(PROT_NUM)
  ) u_decode (
    .addr_i     (addr_i),
    .key_hit_o  (key_hit),
    .io_space_o (io_space),
    .prot_hit_o (prot_hit)
  );

  // DMA strobe never reaches the key or cancel logic
  assign key_wr   = cpu_wr_i && key_hit;
  assign sig_io   = key_wr && (wdata_i == SIG_IO);
  assign sig_nvm  = key_wr && (wdata_i == SIG_NVM);
  assign bad_key  = key_wr && !sig_io && !sig_nvm;
  assign other_wr = cpu_wr_i && !key_hit;

  assign cancel_io  = other_wr ||
                      (retire_i && (ins_store_i || ins_load_i || ins_sleep_i));
  assign cancel_nvm = (other_wr && !io_space) || (retire_i && ins_sleep_i);

  cfg_guard_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sig_io_i     (sig_io),
    .sig_nvm_i    (sig_nvm),
    .bad_key_i    (bad_key),
    .retire_i     (retire_i),
    .cancel_io_i  (cancel_io),
    .cancel_nvm_i (cancel_nvm),
    .mode_o       (mode)
  );

  assign io_open_o  = (mode == MODE_IO);
  assign nvm_open_o = (mode == MODE_NVM);
  assign irq_hold_o = (mode != MODE_NONE);
  assign mode_o     = mode;
  assign prot_wr_o  = other_wr && io_open_o && prot_hit &&
                      wdata_i[CE_BIT] && !fuse_lock_i;
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] KEY_ADDR = 16'h0034,
  parameter logic [7:0]    SIG_IO   = 8'hA5,
  parameter logic [7:0]    SIG_NVM  = 8'h5A
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_wr_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic          retire_i,
  input logic          ins_sleep_i,
  input logic          fuse_lock_i,
  input logic          io_open_o,
  input logic          nvm_open_o,
  input logic          prot_wr_o,
  input logic          irq_hold_o,
  input logic [1:0]    mode_o
);
  logic key_wr;
  assign key_wr = cpu_wr_i && (addr_i == KEY_ADDR);

  p_one_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_open_o, nvm_open_o}) && (mode_o != 2'd3));

  p_sig_io_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr && wdata_i == SIG_IO |=> io_open_o && mode_o == 2'd1);

  p_sig_nvm_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr && wdata_i == SIG_NVM |=> nvm_open_o && mode_o == 2'd2);

  // R4: without a CPU write nothing can open a window
  p_no_open_without_cpu_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_open_o && !nvm_open_o && !cpu_wr_i |=> !io_open_o && !nvm_open_o);

  p_hold_tracks_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hold_o == (io_open_o || nvm_open_o));

  p_sleep_closes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && ins_sleep_i && !key_wr |=> !io_open_o && !nvm_open_o);

  p_grant_needs_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_wr_o |-> io_open_o && cpu_wr_i);

  p_grant_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_wr_o |=> !io_open_o);

  p_fuse_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_lock_i |-> !prot_wr_o);

  p_bad_key_closes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr && wdata_i != SIG_IO && wdata_i != SIG_NVM |=> mode_o == 2'd0);
endmodule

bind cfg_guard cfg_guard_chk #(
  .AW(AW), .KEY_ADDR(KEY_ADDR), .SIG_IO(SIG_IO), .SIG_NVM(SIG_NVM)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_wr_i    (cpu_wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .retire_i    (retire_i),
  .ins_sleep_i (ins_sleep_i),
  .fuse_lock_i (fuse_lock_i),
  .io_open_o   (io_open_o),
  .nvm_open_o  (nvm_open_o),
  .prot_wr_o   (prot_wr_o),
  .irq_hold_o  (irq_hold_o),
  .mode_o      (mode_o)
);

// File: tb/cfg_guard_tb.sv
module cfg_guard_tb;
  localparam logic [15:0] KEY   = 16'h0034;
  localparam logic [15:0] IOLIM = 16'h1000;
  localparam logic [15:0] PBASE = 16'h0040;
  localparam logic [15:0] PEND  = 16'h0048;
  localparam logic [7:0]  S_IO  = 8'hA5;
  localparam logic [7:0]  S_NVM = 8'h5A;
  localparam int          WIN   = 4;

  typedef struct {
    string    tag;
    bit [1:0] mode;
    bit       grant;
  } exp_t;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cpu_wr_i = 0, dma_wr_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        retire_i = 0, ins_store_i = 0, ins_load_i = 0, ins_sleep_i = 0;
  logic        fuse_lock_i = 0;
  logic        io_open_o, nvm_open_o, prot_wr_o, irq_hold_o;
  logic [1:0]  mode_o;

  int   errors = 0, checks = 0;
  bit   done = 0;
  exp_t q[$];

  int m_mode = 0;
  int m_cnt  = 0;

  always #4 clk_i = ~clk_i;

  cfg_guard u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_wr_i(cpu_wr_i), .dma_wr_i(dma_wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .retire_i(retire_i),
    .ins_store_i(ins_store_i), .ins_load_i(ins_load_i), .ins_sleep_i(ins_sleep_i),
    .fuse_lock_i(fuse_lock_i), .io_open_o(io_open_o), .nvm_open_o(nvm_open_o),
    .prot_wr_o(prot_wr_o), .irq_hold_o(irq_hold_o), .mode_o(mode_o)
  );

  task automatic step(string tag, bit cpu, bit dma, logic [15:0] a, logic [7:0] d,
                      bit ret, bit st, bit ld, bit sl, bit fuse);
    exp_t e;
    bit   key, other, can;
    @(negedge clk_i);
    cpu_wr_i = cpu; dma_wr_i = dma; addr_i = a; wdata_i = d;
    retire_i = ret; ins_store_i = st; ins_load_i = ld; ins_sleep_i = sl;
    fuse_lock_i = fuse;
    key   = cpu && (a == KEY);
    other = cpu && (a != KEY);
    e.tag   = tag;
    e.mode  = 2'(m_mode);
    e.grant = other && m_mode == 1 && a >= PBASE && a < PEND && d[0] && !fuse;
    q.push_back(e);
    can = (m_mode == 1 && (other || (ret && (st || ld || sl)))) ||
          (m_mode == 2 && ((other && a >= IOLIM) || (ret && sl)));
    if (key && d == S_IO)       begin m_mode = 1; m_cnt = WIN; end
    else if (key && d == S_NVM) begin m_mode = 2; m_cnt = WIN; end
    else if (key || can)        begin m_mode = 0; m_cnt = 0; end
    else if (m_mode != 0 && ret) begin
      m_cnt--;
      if (m_cnt == 0) m_mode = 0;
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 16'h0, 8'h0, 0, 0, 0, 0, 0);
  endtask
  task automatic ret(string tag, bit st, bit ld, bit sl);
    step(tag, 0, 0, 16'h0, 8'h0, 1, st, ld, sl, 0);
  endtask
  task automatic key(string tag, logic [7:0] d);
    step(tag, 1, 0, KEY, d, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(string tag, logic [15:0] a, logic [7:0] d, bit fuse);
    step(tag, 1, 0, a, d, 0, 0, 0, 0, fuse);
  endtask

  // monitor: compares every cycle's outputs to the queued prediction
  initial begin
    exp_t e;
    bit   ok;
    forever begin
      @(negedge clk_i);
      #3;
      if (q.size() > 0) begin
        e  = q.pop_front();
        ok = (mode_o == e.mode) && (io_open_o == (e.mode == 2'd1)) &&
             (nvm_open_o == (e.mode == 2'd2)) && (irq_hold_o == (e.mode != 2'd0)) &&
             (prot_wr_o == e.grant);
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s: mode=%0d io=%0b nvm=%0b hold=%0b grant=%0b expected mode=%0d grant=%0b",
                   e.tag, mode_o, io_open_o, nvm_open_o, irq_hold_o, prot_wr_o, e.mode, e.grant);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expected=finish actual=timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #10;
    checks++;
    if (io_open_o || nvm_open_o || prot_wr_o || irq_hold_o || mode_o != 0) begin
      errors++;
      $display("FAIL R1 in reset: mode=%0d io=%0b nvm=%0b grant=%0b hold=%0b expected all 0",
               mode_o, io_open_o, nvm_open_o, prot_wr_o, irq_hold_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    idle("R1 after reset");

    // R2 R3 R5: register-write window counts out
    key("R2 sig io", S_IO);
    for (int i = 0; i < WIN; i++) ret("R3 io count", 0, 0, 0);
    idle("R3 io closed");
    key("R2 sig nvm", S_NVM);
    for (int i = 0; i < WIN; i++) ret("R3 nvm count", 0, 0, 0);
    idle("R5 hold dropped");

    // retire in the signature cycle is not counted (R3)
    step("R3 sig with retire", 1, 0, KEY, S_IO, 1, 0, 0, 0, 0);
    for (int i = 0; i < WIN; i++) ret("R3 uncounted", 0, 0, 0);
    idle("R3 uncounted closed");

    // R4: DMA
    step("R4 dma key", 0, 1, KEY, S_IO, 0, 0, 0, 0, 0);
    idle("R4 no window");
    key("R4 open", S_IO);
    step("R4 dma io write", 0, 1, 16'h0041, 8'h01, 0, 0, 0, 0, 0);
    step("R4 dma mem write", 0, 1, 16'h2000, 8'h00, 0, 0, 0, 0, 0);
    idle("R4 still open");

    // R6: register-write mode cancels
    key("R6 open", S_IO);
    wr("R6 io write", 16'h0010, 8'h00, 0);
    idle("R6 closed by write");
    key("R6 open", S_IO);
    ret("R6 load", 0, 1, 0);
    idle("R6 closed by load");
    key("R6 open", S_IO);
    ret("R6 store", 1, 0, 0);
    idle("R6 closed by store");
    key("R6 open", S_IO);
    ret("R6 sleep", 0, 0, 1);
    idle("R6 closed by sleep");

    // R7: flash-instruction mode cancels
    key("R7 open", S_NVM);
    wr("R7 io write keeps", 16'h0010, 8'h00, 0);
    ret("R7 store keeps", 1, 0, 0);
    ret("R7 load keeps", 0, 1, 0);
    wr("R7 mem write", 16'h2000, 8'h00, 0);
    idle("R7 closed by mem write");
    key("R7 open", S_NVM);
    ret("R7 sleep", 0, 0, 1);
    idle("R7 closed by sleep");

    // R8 R9: grant
    key("R8 open", S_IO);
    wr("R8 grant", 16'h0040, 8'h01, 0);
    idle("R8 closed after grant");
    key("R8 open", S_IO);
    ret("R8 late", 0, 0, 0); ret("R8 late", 0, 0, 0); ret("R8 late", 0, 0, 0);
    wr("R8 grant at last slot", 16'h0047, 8'h03, 0);
    idle("R8 closed");
    key("R8 open", S_IO);
    wr("R8 no ce bit", 16'h0042, 8'hFE, 0);
    key("R8 open", S_IO);
    wr("R8 out of range", 16'h0048, 8'h01, 0);
    key("R8 open", S_IO);
    wr("R8 below range", 16'h003F, 8'h01, 0);
    wr("R8 no window", 16'h0040, 8'h01, 0);
    key("R8 nvm mode", S_NVM);
    wr("R8 nvm mode no grant", 16'h0040, 8'h01, 0);
    key("R9 open", S_IO);
    wr("R9 fuse blocks", 16'h0040, 8'h01, 1);
    idle("R9 closed");

    // R10
    key("R10 open", S_IO);
    key("R10 bad value", 8'h00);
    idle("R10 closed");
    key("R10 bad idle", 8'h33);
    idle("R10 none opened");

    // R11
    key("R11 open io", S_IO);
    ret("R11 io", 0, 0, 0); ret("R11 io", 0, 0, 0); ret("R11 io", 0, 0, 0);
    key("R11 switch nvm", S_NVM);
    for (int i = 0; i < WIN; i++) ret("R11 restarted", 0, 0, 0);
    idle("R11 closed");
    key("R11 open nvm", S_NVM);
    ret("R11 nvm", 0, 0, 0);
    key("R11 switch io", S_IO);
    wr("R11 grant after switch", 16'h0044, 8'h01, 0);
    idle("R11 end");
    idle("drain");
    @(negedge clk_i); #5;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule